// File: doc/BRIEF.md
# I2C Byte Master

This block is a single-master I2C controller that a processor drives one byte at a time through four byte-wide registers: a clock divider, a control register, a status register and a data register. Software starts a transaction by setting the master bit. It then writes the slave address and R/W bit into the data register and moves data with further data-register writes (transmit) or reads (receive). It ends the transaction by clearing the master bit, or chains a new address phase with the restart bit. The open-drain SCL and SDA wires appear as an active-high pull-low enable per line plus a sensed input per line.

Each bus bit is built from four quarter-periods timed by the divider, so SDA only moves while SCL is low, except on the START and STOP edges. After the ninth clock of every byte the block raises a byte-complete flag and, if enabled, an interrupt line. In receive mode the acknowledge level for each byte is fixed when that byte starts. This allows software to end a read with a NACK by setting the no-acknowledge bit before the data-register read that launches the last byte. A bus monitor on the sensed wires tracks whether the bus is busy.

Register map (reg_addr): 0 divider, 1 control, 2 status, 3 data. Control bits: 7 enable, 6 interrupt enable, 5 master, 4 transmit select, 3 no-acknowledge, 2 restart (self-clearing, reads 0), 1..0 spare storage. Status bits: 7 byte complete, 5 bus busy, 0 received NACK (1 = slave did not acknowledge); other bits read 0.

Top module: `i2c_byte_master`

## Requirements
- R1: Writing the control register so that the master bit (bit 5) goes from 0 to 1 with the enable bit (bit 7) set, while the block is idle, puts a START condition (SDA falls while SCL is high) on the bus.
- R2: In transmit mode (control bit 4 = 1), a data-register write shifts the byte out MSB first, then releases SDA for the acknowledge slot and stores the sampled level in status bit 0 (0 = ACK, 1 = NACK).
- R3: Status bit 7 sets after the ninth SCL clock of every byte. The irq output equals that flag gated by control bit 6. Writing the status register with bit 7 = 0 clears the flag; writing bit 7 = 1 leaves it unchanged.
- R4: Status bit 5 sets after a START is sensed on the bus wires and clears after a STOP is sensed.
- R5: While a byte is shifting, the SCL period is 4 x (divider + 1) clock cycles, where the divider is the value written at register 0 (reset value 4).
- R6: Inside a byte, SDA changes only while SCL is low.
- R7: Clearing the master bit while the block holds the bus between bytes produces a STOP and frees the bus.
- R8: Writing control with bits 5 and 2 set while the block holds the bus produces a new START without a STOP. The next data-register write sends the new address byte.
- R9: In receive mode (control bit 4 = 0, master bit set), a data-register read returns the last received byte and starts reception of the next byte.
- R10: The master drives ACK (SDA low) in the acknowledge slot of a received byte when control bit 3 was 0 at the moment that byte started, and NACK (SDA released) when it was 1.
- R11: If the master bit is cleared while a byte is in progress, the STOP follows that byte's acknowledge slot without waiting for a data read. A later data-register read returns that byte and starts no bus activity.
- R12: Setting the master bit while the enable bit is 0 produces no bus activity.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 2 | Register select: 0 divider, 1 control, 2 status, 3 data |
| reg_wr | input | 1 | Register write strobe, one cycle |
| reg_rd | input | 1 | Register read strobe, one cycle (side effect on the data register) |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, combinational from reg_addr |
| irq | output | 1 | Byte-complete interrupt |
| scl_in | input | 1 | Sensed level of the SCL wire |
| sda_in | input | 1 | Sensed level of the SDA wire |
| scl_oe | output | 1 | 1 pulls SCL low |
| sda_oe | output | 1 | 1 pulls SDA low |

## Verification
The bench attaches a behavioural slave that acknowledges only its own address, logs written bytes, serves an incrementing byte stream on reads and records the master's acknowledge for every byte. The main corner case is the end of a read. If the acknowledge level were sampled live instead of at byte start, or the STOP waited for a data read, the slave would see an ACK on the last byte or the bus would stay held after it. A data read after that STOP must leave SCL quiet; a design that relaunched reception there would clock the bus without a START. Further checks cover a repeated START that must not emit a STOP, a wrong address that must report NACK, a status write of 1 that must not clear the byte flag, and a master bit set with enable clear, which must leave the wires untouched.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;
   typedef enum logic [2:0] {
      ST_IDLE, ST_START, ST_HOLD, ST_BIT, ST_STOP, ST_RSTART
   } eng_st_t;

   localparam logic [1:0] A_DIV  = 2'd0;
   localparam logic [1:0] A_CTRL = 2'd1;
   localparam logic [1:0] A_STAT = 2'd2;
   localparam logic [1:0] A_DATA = 2'd3;

   localparam int C_EN  = 7;
   localparam int C_IE  = 6;
   localparam int C_MST = 5;
   localparam int C_TX  = 4;
   localparam int C_NAK = 3;
   localparam int C_RS  = 2;

   localparam int S_DONE = 7;
   localparam int S_BUSY = 5;
   localparam int S_NAK  = 0;
endpackage

// File: rtl/i2cm_clkdiv.sv
module i2cm_clkdiv #(
   parameter int DIV_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [DIV_W-1:0] div,
   output logic             tick
);
   logic [DIV_W-1:0] cnt;

   assign tick = run && (cnt == div);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           cnt <= '0;
      else if (!run || tick) cnt <= '0;
      else                  cnt <= cnt + 1'b1;
   end

   // R5: quarter ticks are spaced div+1 cycles apart
   a_r5_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && div != '0) |=> (!tick || div == '0));
endmodule

// File: rtl/i2cm_busmon.sv
module i2cm_busmon #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_in,
   input  logic sda_in,
   output logic busy
);
   logic scl_s, sda_s, scl_p, sda_p;
   logic start_det, stop_det;

   generate
      if (SYNC_STAGES == 0) begin : g_direct
         assign scl_s = scl_in;
         assign sda_s = sda_in;
      end else begin : g_sync
         logic [SYNC_STAGES-1:0] scl_q, sda_q;
         for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) begin
                  scl_q[i] <= 1'b1;
                  sda_q[i] <= 1'b1;
               end else if (i == 0) begin
                  scl_q[i] <= scl_in;
                  sda_q[i] <= sda_in;
               end else begin
                  scl_q[i] <= scl_q[(i == 0) ? 0 : i-1];
                  sda_q[i] <= sda_q[(i == 0) ? 0 : i-1];
               end
            end
         end
         assign scl_s = scl_q[SYNC_STAGES-1];
         assign sda_s = sda_q[SYNC_STAGES-1];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_p <= 1'b1;
         sda_p <= 1'b1;
      end else begin
         scl_p <= scl_s;
         sda_p <= sda_s;
      end
   end

   assign start_det = scl_s && scl_p && sda_p && !sda_s;
   assign stop_det  = scl_s && scl_p && !sda_p && sda_s;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         busy <= 1'b0;
      else if (start_det) busy <= 1'b1;
      else if (stop_det)  busy <= 1'b0;
   end
endmodule

// File: rtl/i2cm_engine.sv
module i2cm_engine
   import i2cm_pkg::*;
#(
   parameter int BYTE_BITS = 8
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 tick,
   input  logic                 start_cmd,
   input  logic                 stop_cmd,
   input  logic                 rs_cmd,
   input  logic                 tx_cmd,
   input  logic                 rx_cmd,
   input  logic [BYTE_BITS-1:0] tx_byte,
   input  logic                 nak_sel,
   input  logic                 sda_in,
   output logic                 scl_oe,
   output logic                 sda_oe,
   output logic                 active,
   output logic                 byte_end,
   output logic [BYTE_BITS-1:0] rx_byte,
   output logic                 rx_nak
);
   localparam int CNT_W = $clog2(BYTE_BITS + 1);
   localparam logic [CNT_W-1:0] ACK_SLOT = CNT_W'(BYTE_BITS);

   eng_st_t              st;
   logic [1:0]           q;
   logic [CNT_W-1:0]     bitn;
   logic [BYTE_BITS-1:0] sh;
   logic                 is_rx, ack_nak;
   logic                 start_req, stop_req, rs_req, tx_req, rx_req;

   assign active   = (st != ST_IDLE) || start_req;
   assign byte_end = (st == ST_BIT) && tick && (q == 2'd3) && (bitn == ACK_SLOT);
   assign rx_byte  = sh;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st <= ST_IDLE; q <= '0; bitn <= '0; sh <= '0;
         is_rx <= 1'b0; ack_nak <= 1'b0; rx_nak <= 1'b0;
         start_req <= 1'b0; stop_req <= 1'b0; rs_req <= 1'b0;
         tx_req <= 1'b0; rx_req <= 1'b0;
      end else begin
         if (start_cmd) start_req <= 1'b1;
         if (stop_cmd) begin
            if (st == ST_IDLE) start_req <= 1'b0;
            else               stop_req  <= 1'b1;
         end
         if (rs_cmd) rs_req <= 1'b1;
         if (tx_cmd) tx_req <= 1'b1;
         if (rx_cmd) rx_req <= 1'b1;

         case (st)
            ST_IDLE: begin
               stop_req <= 1'b0; rs_req <= 1'b0;
               tx_req <= 1'b0; rx_req <= 1'b0;
               q <= '0;
               if (start_req && !stop_cmd) begin
                  st <= ST_START;
                  start_req <= 1'b0;
               end
            end
            ST_START, ST_RSTART: if (tick) begin
               q <= q + 2'd1;
               if (q == 2'd3) st <= ST_HOLD;
            end
            ST_HOLD: if (tick) begin
               bitn <= '0;
               q    <= '0;
               if (tx_req) begin
                  st <= ST_BIT; is_rx <= 1'b0; sh <= tx_byte; tx_req <= 1'b0;
               end else if (rx_req) begin
                  st <= ST_BIT; is_rx <= 1'b1; ack_nak <= nak_sel; rx_req <= 1'b0;
               end else if (rs_req) begin
                  st <= ST_RSTART; rs_req <= 1'b0;
               end else if (stop_req) begin
                  st <= ST_STOP; stop_req <= 1'b0;
               end
            end
            ST_BIT: if (tick) begin
               q <= q + 2'd1;
               if (q == 2'd2) begin
                  if (bitn == ACK_SLOT) begin
                     if (!is_rx) rx_nak <= sda_in;
                  end else if (is_rx) begin
                     sh <= {sh[BYTE_BITS-2:0], sda_in};
                  end
               end
               if (q == 2'd3) begin
                  if (bitn == ACK_SLOT) begin
                     bitn <= '0;
                     if (stop_req) begin
                        st <= ST_STOP; stop_req <= 1'b0;
                     end else begin
                        st <= ST_HOLD;
                     end
                  end else begin
                     bitn <= bitn + 1'b1;
                     if (!is_rx) sh <= {sh[BYTE_BITS-2:0], 1'b0};
                  end
               end
            end
            ST_STOP: if (tick) begin
               q <= q + 2'd1;
               if (q == 2'd3) st <= ST_IDLE;
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

   // Line drive per state and quarter: 1 pulls the wire low
   always_comb begin
      scl_oe = 1'b0;
      sda_oe = 1'b0;
      case (st)
         ST_START: begin
            scl_oe = (q == 2'd3);
            sda_oe = (q != 2'd0);
         end
         ST_HOLD: begin
            scl_oe = 1'b1;
            sda_oe = 1'b1;
         end
         ST_BIT: begin
            scl_oe = (q == 2'd0) || (q == 2'd3);
            if (bitn == ACK_SLOT) sda_oe = is_rx && !ack_nak;
            else                  sda_oe = !is_rx && !sh[BYTE_BITS-1];
         end
         ST_STOP: begin
            scl_oe = (q == 2'd0);
            sda_oe = (q == 2'd0) || (q == 2'd1);
         end
         ST_RSTART: begin
            scl_oe = (q == 2'd0) || (q == 2'd3);
            sda_oe = (q == 2'd2) || (q == 2'd3);
         end
         default: ;
      endcase
   end

   // R6: SDA holds while SCL is released inside a byte
   a_r6_sda_steady: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_BIT && $past(st == ST_BIT) && !scl_oe && $past(!scl_oe))
      |-> (sda_oe == $past(sda_oe)));

   // R7: the cycle after a STOP completes, both wires are released
   a_r7_stop_release: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_STOP && tick && q == 2'd3) |=> (!scl_oe && !sda_oe));
endmodule

// File: rtl/i2c_byte_master.sv
module i2c_byte_master
   import i2cm_pkg::*;
#(
   parameter int DIV_W       = 8,
   parameter int DIV_RESET   = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [1:0] reg_addr,
   input  logic       reg_wr,
   input  logic       reg_rd,
   input  logic [7:0] reg_wdata,
   output logic [7:0] reg_rdata,
   output logic       irq,
   input  logic       scl_in,
   input  logic       sda_in,
   output logic       scl_oe,
   output logic       sda_oe
);
   localparam int BYTE_BITS = 8;

   generate
      if (DIV_W < 2 || DIV_W > 8) begin : g_bad_div
         $error("i2c_byte_master: DIV_W must lie in 2..8");
      end
      if (SYNC_STAGES > 4) begin : g_bad_sync
         $error("i2c_byte_master: SYNC_STAGES must not exceed 4");
      end
      if (DIV_RESET < 0 || DIV_RESET >= (1 << DIV_W)) begin : g_bad_rst
         $error("i2c_byte_master: DIV_RESET does not fit DIV_W");
      end
   endgenerate

   logic [DIV_W-1:0]     div_q;
   logic [7:0]           ctrl_q;
   logic [BYTE_BITS-1:0] txd_q, rxd_q;
   logic                 done_q;
   logic                 tick, eng_active, byte_end, rx_nak, bus_busy;
   logic [BYTE_BITS-1:0] rx_byte;
   logic                 ctrl_wr, data_wr, data_rd, stat_wr;
   logic                 start_cmd, stop_cmd, rs_cmd, tx_cmd, rx_cmd;

   assign ctrl_wr = reg_wr && (reg_addr == A_CTRL);
   assign data_wr = reg_wr && (reg_addr == A_DATA);
   assign stat_wr = reg_wr && (reg_addr == A_STAT);
   assign data_rd = reg_rd && (reg_addr == A_DATA);

   assign start_cmd = ctrl_wr && reg_wdata[C_MST] && !ctrl_q[C_MST] && reg_wdata[C_EN];
   assign stop_cmd  = ctrl_wr && !reg_wdata[C_MST] && ctrl_q[C_MST];
   assign rs_cmd    = ctrl_wr && reg_wdata[C_RS] && reg_wdata[C_MST] && ctrl_q[C_MST];
   assign tx_cmd    = data_wr && ctrl_q[C_TX] && ctrl_q[C_MST] && eng_active;
   assign rx_cmd    = data_rd && !ctrl_q[C_TX] && ctrl_q[C_MST] && eng_active;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         div_q  <= DIV_W'(DIV_RESET);
         ctrl_q <= '0;
         txd_q  <= '0;
         rxd_q  <= '0;
         done_q <= 1'b0;
      end else begin
         if (reg_wr && reg_addr == A_DIV) div_q <= reg_wdata[DIV_W-1:0];
         if (ctrl_wr) begin
            ctrl_q       <= reg_wdata;
            ctrl_q[C_RS] <= 1'b0;
         end
         if (data_wr) txd_q <= reg_wdata;
         if (byte_end) begin
            done_q <= 1'b1;
            rxd_q  <= rx_byte;
         end else if (stat_wr && !reg_wdata[S_DONE]) begin
            done_q <= 1'b0;
         end
      end
   end

   always_comb begin
      reg_rdata = '0;
      case (reg_addr)
         A_DIV:  reg_rdata[DIV_W-1:0] = div_q;
         A_CTRL: reg_rdata = ctrl_q;
         A_STAT: begin
            reg_rdata[S_DONE] = done_q;
            reg_rdata[S_BUSY] = bus_busy;
            reg_rdata[S_NAK]  = rx_nak;
         end
         default: reg_rdata = rxd_q;
      endcase
   end

   assign irq = done_q && ctrl_q[C_IE];

   i2cm_clkdiv #(.DIV_W(DIV_W)) u_div (
      .clk(clk), .rst_n(rst_n), .run(eng_active), .div(div_q), .tick(tick)
   );

   i2cm_engine #(.BYTE_BITS(BYTE_BITS)) u_eng (
      .clk(clk), .rst_n(rst_n), .tick(tick),
      .start_cmd(start_cmd), .stop_cmd(stop_cmd), .rs_cmd(rs_cmd),
      .tx_cmd(tx_cmd), .rx_cmd(rx_cmd), .tx_byte(txd_q), .nak_sel(ctrl_q[C_NAK]),
      .sda_in(sda_in), .scl_oe(scl_oe), .sda_oe(sda_oe), .active(eng_active),
      .byte_end(byte_end), .rx_byte(rx_byte), .rx_nak(rx_nak)
   );

   i2cm_busmon #(.SYNC_STAGES(SYNC_STAGES)) u_mon (
      .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in), .busy(bus_busy)
   );

   // R3: the byte flag only rises at the end of a ninth clock
   a_r3_done_on_byte: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done_q) |-> $past(byte_end));

   // R12: with enable clear and the engine idle, no transfer begins
   a_r12_no_start_disabled: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctrl_q[C_EN] && !ctrl_wr && !eng_active) |=> !eng_active);
endmodule

// File: tb/sim_i2c_byte_master.sv
module sim_i2c_byte_master;
   localparam logic [1:0] RA_DIV = 2'd0, RA_CTRL = 2'd1, RA_STAT = 2'd2, RA_DATA = 2'd3;
   localparam logic [6:0] SLV = 7'h2A;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] reg_addr = '0;
   logic       reg_wr = 1'b0, reg_rd = 1'b0;
   logic [7:0] reg_wdata = '0;
   logic [7:0] reg_rdata;
   logic       irq, scl_oe, sda_oe;
   logic       s_low = 1'b0;
   wire        scl_w = ~scl_oe;
   wire        sda_w = ~(sda_oe | s_low);

   int nchk = 0, nfail = 0, cyc = 0;
   bit finished = 0;

   always #2 clk = ~clk;
   always @(posedge clk) cyc++;

   i2c_byte_master u0 (
      .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
      .scl_in(scl_w), .sda_in(sda_w), .scl_oe(scl_oe), .sda_oe(sda_oe)
   );

   // Behavioural slave
   int nstart = 0, nstop = 0, nlog = 0, nm = 0, nfall = 0, rdx = 0, bitn = 0;
   logic [7:0] sh = '0, txb = '0;
   logic [7:0] wlog [16];
   logic       mlog [16];
   logic active = 0, addrd = 0, rd = 0, sending = 0, quit = 0, mack = 0;

   always @(negedge sda_w) if (scl_w) begin
      nstart++; active = 1; bitn = 0; addrd = 0; sending = 0; quit = 0; s_low = 0;
   end
   always @(posedge sda_w) if (scl_w) begin
      nstop++; active = 0; s_low = 0;
   end
   always @(posedge scl_w) if (active) begin
      if (bitn < 8) sh = {sh[6:0], sda_w};
      else if (bitn == 8) mack = !sda_w;
      bitn++;
   end
   always @(negedge scl_w) begin
      nfall++;
      if (active) begin
         if (bitn == 8) begin
            if (!addrd) begin
               if (sh[7:1] == SLV) begin addrd = 1; rd = sh[0]; s_low = 1; end
               else begin active = 0; s_low = 0; end
            end else if (!rd) begin
               wlog[nlog % 16] = sh; nlog++; s_low = 1;
            end else s_low = 0;
         end else if (bitn == 9) begin
            bitn = 0;
            if (rd && sending) begin
               mlog[nm % 16] = mack; nm++;
               if (!mack) quit = 1;
            end
            if (rd && !quit) begin
               txb = 8'hA0 + 8'(rdx); rdx++; sending = 1; s_low = ~txb[7];
            end else s_low = 0;
         end else if (rd && sending && !quit && bitn >= 1 && bitn <= 7) begin
            s_low = ~txb[7-bitn];
         end
      end
   end

   task automatic finish_run();
      if (!finished) begin
         finished = 1;
         $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
         $finish;
      end
   endtask

   task automatic check(input string req, input int act, input int exp);
      nchk++;
      if (act !== exp) begin
         nfail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic reg_wr_t(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1;
      @(negedge clk); reg_wr = 0;
   endtask

   task automatic reg_rd_t(input logic [1:0] a, output logic [7:0] d);
      @(negedge clk); reg_addr = a; reg_rd = 1; #1 d = reg_rdata;
      @(negedge clk); reg_rd = 0;
   endtask

   task automatic wait_irq(input string req);
      int n = 0;
      while (!irq && n < 5000) begin @(posedge clk); n++; end
      @(negedge clk);
      check({req, " byte complete irq"}, irq, 1);
   endtask

   task automatic wait_busy(input logic v, input string req);
      logic [7:0] s;
      for (int n = 0; n < 500; n++) begin
         reg_rd_t(RA_STAT, s);
         if (s[5] == v) break;
      end
      reg_rd_t(RA_STAT, s);
      check({req, " bus busy"}, s[5], v);
   endtask

   task automatic scl_period(input int exp, input string req);
      int t0, t1;
      @(posedge scl_w); t0 = cyc;
      @(posedge scl_w); t1 = cyc;
      check({req, " scl period"}, t1 - t0, exp);
   endtask

   task automatic t_reset();
      logic [7:0] d;
      check("R1 reset scl released", scl_oe, 0);
      check("R1 reset sda released", sda_oe, 0);
      check("R3 reset irq", irq, 0);
      reg_rd_t(RA_CTRL, d); check("R1 reset control", d, 8'h00);
      reg_rd_t(RA_STAT, d); check("R4 reset status", d, 8'h00);
      reg_rd_t(RA_DIV, d);  check("R5 reset divider", d, 8'd4);
   endtask

   task automatic t_disabled();
      int s0 = nstart, f0 = nfall;
      reg_wr_t(RA_CTRL, 8'h20);
      repeat (100) @(posedge clk);
      @(negedge clk);
      check("R12 no start when disabled", nstart, s0);
      check("R12 scl untouched", nfall, f0);
      reg_wr_t(RA_CTRL, 8'h00);
   endtask

   task automatic t_write();
      logic [7:0] s;
      int s0 = nstart, p0 = nstop, l0 = nlog;
      reg_wr_t(RA_DIV, 8'd3);
      reg_wr_t(RA_CTRL, 8'hF0);
      wait_busy(1, "R4 after start");
      check("R1 start seen", nstart, s0 + 1);
      reg_wr_t(RA_DATA, 8'h54);
      scl_period(16, "R5 div 3");
      wait_irq("R3 addr");
      reg_rd_t(RA_STAT, s);
      check("R3 done flag", s[7], 1);
      check("R2 address acked", s[0], 0);
      reg_wr_t(RA_STAT, 8'h80);
      check("R3 write 1 keeps flag", irq, 1);
      reg_wr_t(RA_STAT, 8'h00);
      check("R3 write 0 clears flag", irq, 0);
      reg_wr_t(RA_DATA, 8'hC3);
      wait_irq("R3 data");
      reg_wr_t(RA_STAT, 8'h00);
      reg_wr_t(RA_CTRL, 8'hD0);
      wait_busy(0, "R4 after stop");
      check("R7 stop seen", nstop, p0 + 1);
      check("R2 one byte logged", nlog, l0 + 1);
      check("R2 byte msb first", wlog[l0 % 16], 8'hC3);
   endtask

   task automatic t_badaddr();
      logic [7:0] s;
      reg_wr_t(RA_DIV, 8'd6);
      reg_wr_t(RA_CTRL, 8'hF0);
      wait_busy(1, "R1 second start");
      reg_wr_t(RA_DATA, 8'h50);
      scl_period(28, "R5 div 6");
      wait_irq("R2 bad addr");
      reg_rd_t(RA_STAT, s);
      check("R2 nack recorded", s[0], 1);
      reg_wr_t(RA_STAT, 8'h00);
      reg_wr_t(RA_CTRL, 8'hD0);
      wait_busy(0, "R7 stop after nack");
      reg_wr_t(RA_DIV, 8'd3);
   endtask

   task automatic t_restart();
      int s0 = nstart, p0 = nstop, l0 = nlog;
      logic [7:0] s;
      reg_wr_t(RA_CTRL, 8'hF0);
      wait_busy(1, "R8 start");
      reg_wr_t(RA_DATA, 8'h54); wait_irq("R8 addr1"); reg_wr_t(RA_STAT, 8'h00);
      reg_wr_t(RA_DATA, 8'h11); wait_irq("R8 data1"); reg_wr_t(RA_STAT, 8'h00);
      reg_wr_t(RA_CTRL, 8'hF4);
      repeat (100) @(posedge clk);
      @(negedge clk);
      check("R8 second start", nstart, s0 + 2);
      check("R8 no stop before restart", nstop, p0);
      reg_wr_t(RA_DATA, 8'h54); wait_irq("R8 addr2");
      reg_rd_t(RA_STAT, s);
      check("R8 new address acked", s[0], 0);
      reg_wr_t(RA_STAT, 8'h00);
      reg_wr_t(RA_DATA, 8'h22); wait_irq("R8 data2"); reg_wr_t(RA_STAT, 8'h00);
      reg_wr_t(RA_CTRL, 8'hD0);
      wait_busy(0, "R8 stop");
      check("R8 bytes logged", nlog, l0 + 2);
      check("R8 byte after restart", wlog[(l0 + 1) % 16], 8'h22);
   endtask

   task automatic t_read();
      logic [7:0] d;
      int m0, p0, f0, s0;
      rdx = 0;
      reg_wr_t(RA_CTRL, 8'hF0);
      wait_busy(1, "R9 start");
      reg_wr_t(RA_DATA, 8'h55); wait_irq("R9 addr"); reg_wr_t(RA_STAT, 8'h00);
      m0 = nm;
      reg_wr_t(RA_CTRL, 8'hE0);
      reg_rd_t(RA_DATA, d);                     // dummy read launches byte 1
      wait_irq("R9 byte1"); reg_wr_t(RA_STAT, 8'h00);
      reg_rd_t(RA_DATA, d);
      check("R9 first byte", d, 8'hA0);
      wait_irq("R9 byte2"); reg_wr_t(RA_STAT, 8'h00);
      reg_wr_t(RA_CTRL, 8'hE8);                 // NACK for the byte launched next
      reg_rd_t(RA_DATA, d);
      check("R9 second byte", d, 8'hA1);
      p0 = nstop;
      reg_wr_t(RA_CTRL, 8'hC8);                 // STOP requested mid-byte
      wait_irq("R11 byte3");
      wait_busy(0, "R11 stop without read");
      check("R11 stop after last ack", nstop, p0 + 1);
      check("R10 byte1 acked", mlog[m0 % 16], 1);
      check("R10 byte2 acked", mlog[(m0 + 1) % 16], 1);
      check("R10 last byte nacked", mlog[(m0 + 2) % 16], 0);
      f0 = nfall; s0 = nstart;
      reg_rd_t(RA_DATA, d);
      check("R11 final byte", d, 8'hA2);
      repeat (200) @(posedge clk);
      @(negedge clk);
      check("R11 no clocks after final read", nfall, f0);
      check("R11 no start after final read", nstart, s0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      nchk++; nfail++;
      $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
      finish_run();
   end

   initial begin
      repeat (4) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;
      repeat (2) @(negedge clk);
      t_reset();
      t_disabled();
      t_write();
      t_badaddr();
      t_restart();
      t_read();
      finish_run();
   end
endmodule